// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit resolves conditional branches for a processor that splits comparison and branching into two instructions. A compare instruction hands the unit two 32-bit values read from the register file. The unit stores them unchanged and computes no flags. A later branch instruction, presented as a 16-bit word with its own PC, names one of ten relations. The relation is evaluated on the stored pair, first operand against second, at the moment the branch arrives.

One cycle after a branch is presented, the unit reports whether the branch was taken, and it reports the next PC. That PC is the branch target when taken and the fall-through address when not taken. A branch word that carries an unused condition code produces a bad-instruction strobe instead. In that case the reported PC points back at the faulting instruction, so the exception logic outside the unit can save it. Register-file reads, instruction fetch and exception handling are outside the unit.

Top module: `cmpbr_unit`

## Requirements
- R1: The unit treats a word as a branch only when `insn_valid` is high and bits 15 and 14 of `insn_word` are both 1. Any other word, and any word with `insn_valid` low, produces no `res_valid`, `res_taken` or `bad_insn` pulse and leaves `res_next_pc` unchanged.
- R2: The branch offset is `insn_word[9:0]`, sign-extended as a 10-bit value and doubled. The taken target is `insn_pc + 2 + offset`, modulo 2^32.
- R3: When a valid branch is not taken, `res_next_pc` becomes `insn_pc + 2`.
- R4: Both stored operands are zero after reset. They take `cmp_a_in` and `cmp_b_in` unchanged at a clock edge where `cmp_load` is high, and they hold their value at every other edge.
- R5: The signed relations, selected by `insn_word[13:10]`, are: 0 equal, 1 not equal, 2 less than, 3 greater than, 6 greater or equal, 7 less or equal. Each compares the first stored operand with the second, both taken as two's complement.
- R6: The unsigned relations are: 4 less than, 5 greater than, 8 greater or equal, 9 less or equal. Each compares the first stored operand with the second.
- R7: A branch word whose condition code is 10 to 15 gives a one-cycle `bad_insn` pulse with `res_valid` and `res_taken` low, and `res_next_pc` equal to that word's `insn_pc`.
- R8: Results are registered. `res_valid`, `res_taken` and `bad_insn` pulse in the cycle after the instruction is presented. `res_taken` is never high without `res_valid`. After reset, all outputs are zero. Branches may arrive back to back, one per cycle.
- R9: A branch presented in the same cycle as a compare load is evaluated on the operands stored before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_load | input | 1 | Compare strobe; stores both operands |
| cmp_a_in | input | 32 | First compare operand (register A) |
| cmp_b_in | input | 32 | Second compare operand (register B) |
| insn_valid | input | 1 | Qualifies `insn_word` and `insn_pc` |
| insn_word | input | 16 | Instruction word |
| insn_pc | input | 32 | Address of the presented instruction |
| res_valid | output | 1 | A branch was resolved last cycle |
| res_taken | output | 1 | The resolved branch was taken |
| bad_insn | output | 1 | The branch had an unused condition code |
| res_next_pc | output | 32 | Next PC, or the faulting PC on `bad_insn` |

## Verification
The bench picks operand pairs that separate the signed and unsigned orderings, for example a negative value against a small positive one. A design that mixed the two families up would then take the wrong direction on conditions 2 to 9. Equal operands are applied to every code, which catches a strict relation that was built as non-strict (or the reverse). The offset extremes +511, -512 and -1 catch a zero-extended or undoubled offset, and a PC near 2^32 checks that the target wraps. Four further cases each have their own failure mode:
- An unused condition code must report the faulting PC. A design that gets this wrong reports a fall-through address.
- A compare and a branch in the same cycle must use the old operands. A design that gets this wrong takes the wrong direction.
- A changed operand input without the load strobe must not be stored. A design that stores it anyway takes the wrong direction on the next branch.
- A non-branch word must not disturb the result. A design that decodes it anyway raises a spurious strobe or changes the next PC.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;

  // Relation codes carried in the branch word's condition field.
  typedef enum logic [3:0] {
    REL_EQ  = 4'd0,
    REL_NE  = 4'd1,
    REL_LT  = 4'd2,
    REL_GT  = 4'd3,
    REL_LTU = 4'd4,
    REL_GTU = 4'd5,
    REL_GE  = 4'd6,
    REL_LE  = 4'd7,
    REL_GEU = 4'd8,
    REL_LEU = 4'd9
  } rel_code_e;

  localparam int unsigned NUM_REL = 10;

endpackage

// File: rtl/cmpbr_operands.sv
module cmpbr_operands #(
  parameter int unsigned XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [XW-1:0] a_in,
  input  logic [XW-1:0] b_in,
  output logic [XW-1:0] opa_q,
  output logic [XW-1:0] opb_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (load) begin
      opa_q <= a_in;
      opb_q <= b_in;
    end
  end

endmodule

// File: rtl/cmpbr_decode.sv
module cmpbr_decode #(
  parameter int unsigned XW      = 32,
  parameter int unsigned IW      = 16,
  parameter int unsigned CW      = 4,
  parameter int unsigned OW      = 10,
  parameter int unsigned NREL    = 10
) (
  input  logic [IW-1:0] insn,
  input  logic [XW-1:0] pc,
  output logic          is_branch,
  output logic [CW-1:0] cond,
  output logic          cond_known,
  output logic [XW-1:0] target,
  output logic [XW-1:0] fallthru
);

  localparam int unsigned STEP = IW / 8;

  // Sign-extend the halfword offset and scale it to bytes.
  function automatic logic [XW-1:0] scaled_offset(input logic [OW-1:0] raw);
    logic [XW-1:0] ext;
    ext = {{(XW-OW){raw[OW-1]}}, raw};
    return ext << 1;
  endfunction

  assign is_branch  = insn[IW-1] & insn[IW-2];
  assign cond       = insn[IW-3 -: CW];
  assign cond_known = ({28'd0, cond} < NREL);
  assign fallthru   = pc + XW'(STEP);
  assign target     = fallthru + scaled_offset(insn[OW-1:0]);

endmodule

// File: rtl/cmpbr_relation.sv
module cmpbr_relation
  import cmpbr_pkg::*;
#(
  parameter int unsigned XW   = 32,
  parameter int unsigned CW   = 4,
  parameter int unsigned NREL = 10
) (
  input  logic [XW-1:0] opa,
  input  logic [XW-1:0] opb,
  input  logic [CW-1:0] cond,
  output logic          holds
);

  localparam int unsigned NCODE = 1 << CW;

  function automatic logic rel_eval(input int unsigned code,
                                    input logic [XW-1:0] a,
                                    input logic [XW-1:0] b);
    logic eq, lts, ltu;
    eq  = (a == b);
    lts = ($signed(a) < $signed(b));
    ltu = (a < b);
    case (code)
      32'(REL_EQ):  return eq;
      32'(REL_NE):  return !eq;
      32'(REL_LT):  return lts;
      32'(REL_GT):  return !lts && !eq;
      32'(REL_LTU): return ltu;
      32'(REL_GTU): return !ltu && !eq;
      32'(REL_GE):  return !lts;
      32'(REL_LE):  return lts || eq;
      32'(REL_GEU): return !ltu;
      32'(REL_LEU): return ltu || eq;
      default:      return 1'b0;
    endcase
  endfunction

  logic [NCODE-1:0] rel_vec;

  for (genvar k = 0; k < NCODE; k++) begin : g_rel
    if (k < NREL) begin : g_used
      assign rel_vec[k] = rel_eval(k, opa, opb);
    end else begin : g_unused
      assign rel_vec[k] = 1'b0;
    end
  end

  assign holds = rel_vec[cond];

endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
  import cmpbr_pkg::*;
#(
  parameter int unsigned XW = 32,
  parameter int unsigned IW = 16,
  parameter int unsigned CW = 4,
  parameter int unsigned OW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_load,
  input  logic [XW-1:0] cmp_a_in,
  input  logic [XW-1:0] cmp_b_in,
  input  logic          insn_valid,
  input  logic [IW-1:0] insn_word,
  input  logic [XW-1:0] insn_pc,
  output logic          res_valid,
  output logic          res_taken,
  output logic          bad_insn,
  output logic [XW-1:0] res_next_pc
);

  logic [XW-1:0] opa_q, opb_q;
  logic          is_branch, cond_known, rel_holds;
  logic [CW-1:0] cond;
  logic [XW-1:0] target, fallthru;

  // Named events for the checker.
  logic br_fire, bad_fire;

  cmpbr_operands #(.XW(XW)) u_ops (
    .clk(clk), .rst_n(rst_n), .load(cmp_load),
    .a_in(cmp_a_in), .b_in(cmp_b_in),
    .opa_q(opa_q), .opb_q(opb_q)
  );

  cmpbr_decode #(.XW(XW), .IW(IW), .CW(CW), .OW(OW), .NREL(NUM_REL)) u_dec (
    .insn(insn_word), .pc(insn_pc),
    .is_branch(is_branch), .cond(cond), .cond_known(cond_known),
    .target(target), .fallthru(fallthru)
  );

  cmpbr_relation #(.XW(XW), .CW(CW), .NREL(NUM_REL)) u_rel (
    .opa(opa_q), .opb(opb_q), .cond(cond), .holds(rel_holds)
  );

  assign br_fire  = insn_valid & is_branch & cond_known;
  assign bad_fire = insn_valid & is_branch & ~cond_known;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      bad_insn    <= 1'b0;
      res_next_pc <= '0;
    end else begin
      res_valid <= br_fire;
      res_taken <= br_fire & rel_holds;
      bad_insn  <= bad_fire;
      if (br_fire)
        res_next_pc <= rel_holds ? target : fallthru;
      else if (bad_fire)
        res_next_pc <= insn_pc;
    end
  end

endmodule

// File: rtl/cmpbr_unit_chk.sv
module cmpbr_unit_chk #(
  parameter int unsigned XW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmp_load,
  input logic [XW-1:0] cmp_a_in,
  input logic [XW-1:0] cmp_b_in,
  input logic          insn_valid,
  input logic [XW-1:0] insn_pc,
  input logic          res_valid,
  input logic          res_taken,
  input logic          bad_insn,
  input logic [XW-1:0] res_next_pc,
  input logic [XW-1:0] opa_q,
  input logic [XW-1:0] opb_q,
  input logic          br_fire,
  input logic          bad_fire
);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> (!res_valid && !bad_insn));

  assert_fallthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    br_fire |=> (res_valid && (res_taken || res_next_pc == $past(insn_pc) + XW'(2))));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_load |=> ($stable(opa_q) && $stable(opb_q)));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_load |=> (opa_q == $past(cmp_a_in) && opb_q == $past(cmp_b_in)));

  assert_badpc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fire |=> (bad_insn && !res_valid && res_next_pc == $past(insn_pc)));

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && bad_insn));

  assert_taken_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_taken |-> res_valid);

endmodule

bind cmpbr_unit cmpbr_unit_chk #(.XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_load(cmp_load),
  .cmp_a_in(cmp_a_in), .cmp_b_in(cmp_b_in),
  .insn_valid(insn_valid), .insn_pc(insn_pc),
  .res_valid(res_valid), .res_taken(res_taken), .bad_insn(bad_insn),
  .res_next_pc(res_next_pc), .opa_q(opa_q), .opb_q(opb_q),
  .br_fire(br_fire), .bad_fire(bad_fire)
);

// File: tb/cmpbr_unit_bench.sv
`timescale 1ns/1ps
module cmpbr_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_load = 1'b0;
  logic [31:0] cmp_a_in = '0, cmp_b_in = '0;
  logic        insn_valid = 1'b0;
  logic [15:0] insn_word = '0;
  logic [31:0] insn_pc = '0;
  logic        res_valid, res_taken, bad_insn;
  logic [31:0] res_next_pc;

  always #4 clk = ~clk;

  cmpbr_unit u_cmpbr_unit (
    .clk(clk), .rst_n(rst_n), .cmp_load(cmp_load),
    .cmp_a_in(cmp_a_in), .cmp_b_in(cmp_b_in),
    .insn_valid(insn_valid), .insn_word(insn_word), .insn_pc(insn_pc),
    .res_valid(res_valid), .res_taken(res_taken), .bad_insn(bad_insn),
    .res_next_pc(res_next_pc)
  );

  typedef struct {
    bit          v;
    bit          t;
    bit          b;
    logic [31:0] pc;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_fails  = 0;
  logic [31:0] ref_a = '0, ref_b = '0, ref_npc = '0;

  // Relation model: orderings derived from a 33-bit borrow.
  function automatic bit ref_rel(input int c, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] du, ds;
    bit eq, ltu, lts;
    du  = {1'b0, a} - {1'b0, b};
    ds  = {1'b0, ~a[31], a[30:0]} - {1'b0, ~b[31], b[30:0]};
    eq  = (du[31:0] == 32'd0);
    ltu = du[32];
    lts = ds[32];
    case (c)
      0: return eq;
      1: return !eq;
      2: return lts;
      3: return !(lts || eq);
      4: return ltu;
      5: return !(ltu || eq);
      6: return !lts;
      7: return lts || eq;
      8: return !ltu;
      9: return ltu || eq;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] mk_br(input int c, input logic [9:0] off);
    return {2'b11, 4'(c), off};
  endfunction

  task automatic drive(input bit ld, input logic [31:0] a, input logic [31:0] b,
                       input bit vld, input logic [15:0] w, input logic [31:0] pc,
                       input string tag);
    exp_t e;
    int   c;
    logic [31:0] off;
    @(negedge clk);
    cmp_load = ld; cmp_a_in = a; cmp_b_in = b;
    insn_valid = vld; insn_word = w; insn_pc = pc;
    c   = int'(w[13:10]);
    off = 32'($signed(w[9:0])) * 2;
    e.v = 0; e.t = 0; e.b = 0; e.tag = tag;
    if (vld && w[15] && w[14]) begin
      if (c <= 9) begin
        e.v = 1;
        e.t = ref_rel(c, ref_a, ref_b);
        ref_npc = e.t ? (pc + 32'd2 + off) : (pc + 32'd2);
      end else begin
        e.b = 1;
        ref_npc = pc;
      end
    end
    e.pc = ref_npc;
    sb.push_back(e);
    if (ld) begin
      ref_a = a;
      ref_b = b;
    end
  endtask

  task automatic idle(input string tag);
    drive(0, 32'hDEAD_0001, 32'hDEAD_0002, 0, 16'h0000, 32'h0, tag);
  endtask

  // Monitor: compares one expected item per cycle after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (res_valid !== e.v || res_taken !== e.t || bad_insn !== e.b ||
            res_next_pc !== e.pc) begin
          n_fails++;
          $display("FAIL %s: got v=%0b t=%0b bad=%0b pc=%h, expected v=%0b t=%0b bad=%0b pc=%h",
                   e.tag, res_valid, res_taken, bad_insn, res_next_pc,
                   e.v, e.t, e.b, e.pc);
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    n_checks++;
    if (res_valid !== 0 || res_taken !== 0 || bad_insn !== 0 || res_next_pc !== 0) begin
      n_fails++;
      $display("FAIL R8 reset: got v=%0b t=%0b bad=%0b pc=%h, expected all zero",
               res_valid, res_taken, bad_insn, res_next_pc);
    end

    // R4: zero operands after reset -> equal taken
    drive(0, 32'h0, 32'h0, 1, mk_br(0, 10'd4), 32'h100, "R4 reset operands eq");
    drive(0, 32'h0, 32'h0, 1, mk_br(1, 10'd4), 32'h104, "R4 reset operands ne");

    // R5 R6: small positives, back-to-back (R8)
    drive(1, 32'd5, 32'd7, 0, 16'h0, 32'h0, "R4 load 5,7");
    for (int c = 0; c < 10; c++)
      drive(0, 32'd0, 32'd0, 1, mk_br(c, 10'(c * 3 + 1)), 32'h1000 + 32'(c * 4),
            c inside {4, 5, 8, 9} ? "R6 5vs7" : "R5 5vs7");

    // R5 R6: negative versus positive splits signed and unsigned
    drive(1, 32'hFFFF_FFF0, 32'd3, 0, 16'h0, 32'h0, "R4 load neg,3");
    for (int c = 0; c < 10; c++)
      drive(0, 32'd0, 32'd0, 1, mk_br(c, 10'h3F0), 32'h2000 + 32'(c * 2),
            c inside {4, 5, 8, 9} ? "R6 neg vs 3" : "R5 neg vs 3");

    // Equal operands against every code
    drive(1, 32'h8000_0000, 32'h8000_0000, 0, 16'h0, 32'h0, "R4 load equal");
    for (int c = 0; c < 10; c++)
      drive(0, 32'd0, 32'd0, 1, mk_br(c, 10'd8), 32'h3000,
            c inside {4, 5, 8, 9} ? "R6 equal" : "R5 equal");

    // R2: offset extremes and PC wrap (operands equal -> eq taken)
    drive(0, 0, 0, 1, mk_br(0, 10'h1FF), 32'h4000, "R2 max forward");
    drive(0, 0, 0, 1, mk_br(0, 10'h200), 32'h4000, "R2 max backward");
    drive(0, 0, 0, 1, mk_br(0, 10'h3FF), 32'h4000, "R2 minus one");
    drive(0, 0, 0, 1, mk_br(0, 10'h010), 32'hFFFF_FFF0, "R2 wrap");
    // R3: not taken on wrap
    drive(0, 0, 0, 1, mk_br(1, 10'h010), 32'hFFFF_FFFE, "R3 fallthru wrap");

    // R7: unused codes
    for (int c = 10; c < 16; c++)
      drive(0, 0, 0, 1, mk_br(c, 10'h155), 32'h5000 + 32'(c * 2), "R7 bad code");

    // R1: non-branch words and invalid branch words are ignored
    drive(0, 0, 0, 1, 16'h8123, 32'h6000, "R1 form2 word");
    drive(0, 0, 0, 1, 16'h4123, 32'h6002, "R1 bit14 only");
    drive(0, 0, 0, 1, 16'h0000, 32'h6004, "R1 zero word");
    drive(0, 0, 0, 0, mk_br(0, 10'd2), 32'h6006, "R1 invalid branch");
    drive(0, 0, 0, 0, mk_br(12, 10'd2), 32'h6008, "R1 invalid bad code");

    // R4: inputs change without load, stored operands must hold
    drive(0, 32'd1, 32'd2, 0, 16'h0, 32'h0, "R4 no load");
    drive(0, 32'd1, 32'd2, 1, mk_br(0, 10'd6), 32'h7000, "R4 hold eq");

    // R9: load and branch in one cycle use the old pair
    drive(1, 32'd9, 32'd1, 1, mk_br(0, 10'd6), 32'h7100, "R9 same cycle eq");
    drive(0, 32'd0, 32'd0, 1, mk_br(3, 10'd6), 32'h7200, "R9 after load gt");
    drive(1, 32'd1, 32'd9, 1, mk_br(5, 10'd6), 32'h7300, "R9 same cycle gtu");
    drive(0, 32'd0, 32'd0, 1, mk_br(4, 10'd6), 32'h7400, "R9 after load ltu");

    for (int i = 0; i < 3; i++) idle("R8 idle hold");
    @(negedge clk);
    while (sb.size() > 0) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule